// File: doc/BRIEF.md
# Parking Bus Arbiter

A central arbiter for a shared parallel bus with up to `NUM_MASTERS` masters (default four). Each master has one request line and one grant line. The arbiter watches the shared, active-low frame and initiator-ready signals to learn when the current owner has started a transaction. It picks the next owner in a rotating order while the current transaction is still running, so the next master can be waiting with its grant when the bus goes idle.

When nobody else asks for the bus, the grant stays parked on the last owner, so that master can start another transaction without arbitrating again. An owner that has been granted but has not yet started a transaction keeps the grant until it does. After that first transaction, a competing request takes the grant away. Every change of owner passes through exactly one clock with no grant asserted.

Top module: `parkArbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it, the grant vector equals 0b0001: the grant is parked on master 0.
- R2: At most one grant bit is set in any cycle.
- R3: If no master other than the current owner requests, the grant vector does not change, however many cycles pass.
- R4: A change of owner takes exactly one cycle with the grant vector all zero. The grant bit of the new owner is set on the clock edge after that cycle.
- R5: The new owner is the first requesting master after the current owner in ascending index order, wrapping from the highest index to 0.
- R6: An owner that still requests, and has not yet started a transaction during its tenure, keeps its grant even while other masters request.
- R7: An owner starts a transaction when frame is sampled low at a clock edge after the bus was sampled idle (frame and ready both high) during the same tenure. From the edge where that happens, a competing request removes the grant at that edge, even though the bus is busy.
- R8: An owner that no longer requests loses its grant at the first clock edge at which another master requests.
- R9: The next owner is fixed at the edge that removes the old grant. If that master drops its request during the empty cycle, it still receives the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busReq | input | NUM_MASTERS | Request lines, one per master, active high |
| frameN | input | 1 | Shared frame signal, active low |
| irdyN | input | 1 | Shared initiator-ready signal, active low |
| busGnt | output | NUM_MASTERS | Grant lines, one per master, active high, registered |

## Verification
The arbiter keeps a small amount of internal state: who owns the bus, who is next, and whether the current tenure has seen an idle bus and then a start. A wrong owner or wrong next owner shows on the grant lines within two edges of a competing request: either the wrong bit is set after the empty cycle, or no empty cycle appears. A wrong started or idle flag shows as a grant removed one edge too early, or not removed at the edge where frame first falls after an idle cycle. The bench therefore checks the grant vector at every edge around each handover, including the wrap from the highest index to 0 and a next owner that drops its request during the empty cycle.

// File: rtl/parkArbPkg.sv
package parkArbPkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic revoke;  // drop the current grant, latch the next owner
    logic hand;    // assert the grant of the latched next owner
  } arbStrobe_t;
endpackage

// File: rtl/arbPicker.sv
module arbPicker #(
  parameter int NUM_MASTERS = 4,
  localparam int IdxW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic [IdxW-1:0]        ownerIdx,
  input  logic [NUM_MASTERS-1:0] reqVec,
  output logic [IdxW-1:0]        candIdx,
  output logic                   anyOther
);
  // Walk from the farthest offset to the nearest so the nearest requester wins.
  always_comb begin
    candIdx  = ownerIdx;
    anyOther = 1'b0;
    for (int off = NUM_MASTERS - 1; off >= 1; off--) begin
      int idx;
      idx = (int'(ownerIdx) + off) % NUM_MASTERS;
      if (reqVec[idx]) begin
        candIdx  = idx[IdxW-1:0];
        anyOther = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arbCtrl.sv
module arbCtrl
  import parkArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyOther,
  input  logic       ownerReq,
  input  logic       started,
  output arbStrobe_t stb
);
  typedef enum logic {ST_OWN, ST_GAP} arbState_e;
  arbState_e stateQ;

  always_comb begin
    stb.revoke = (stateQ == ST_OWN) && anyOther && (!ownerReq || started);
    stb.hand   = (stateQ == ST_GAP);
  end

  always_ff @(posedge clk) begin
    if (!rstN)           stateQ <= ST_OWN;
    else if (stb.revoke) stateQ <= ST_GAP;
    else if (stb.hand)   stateQ <= ST_OWN;
  end

  // R4: the empty state lasts exactly one cycle
  p_gap_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_GAP) |=> (stateQ == ST_OWN));
endmodule

// File: rtl/arbPath.sv
module arbPath
  import parkArbPkg::*;
#(
  parameter int NUM_MASTERS = 4,
  localparam int IdxW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  arbStrobe_t             stb,
  input  logic [IdxW-1:0]        candIdx,
  input  logic                   frameN,
  input  logic                   irdyN,
  input  logic [NUM_MASTERS-1:0] reqVec,
  output logic [IdxW-1:0]        ownerIdx,
  output logic                   started,
  output logic [NUM_MASTERS-1:0] gntVec
);
  localparam logic [NUM_MASTERS-1:0] OneHot0 = {{(NUM_MASTERS-1){1'b0}}, 1'b1};

  logic [IdxW-1:0] pendQ;
  logic            idleSeenQ, usedQ;
  logic            granted;

  assign granted = |gntVec;
  assign started = usedQ || (idleSeenQ && !frameN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gntVec    <= OneHot0;
      ownerIdx  <= '0;
      pendQ     <= '0;
      idleSeenQ <= 1'b0;
      usedQ     <= 1'b0;
    end else if (stb.revoke) begin
      gntVec <= '0;
      pendQ  <= candIdx;
    end else if (stb.hand) begin
      gntVec    <= OneHot0 << pendQ;
      ownerIdx  <= pendQ;
      idleSeenQ <= 1'b0;
      usedQ     <= 1'b0;
    end else if (granted) begin
      if (frameN && irdyN)        idleSeenQ <= 1'b1;
      if (idleSeenQ && !frameN)   usedQ     <= 1'b1;
    end
  end

  // R2: never more than one grant
  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gntVec));
  // R4: a grant never moves straight to another master
  p_no_direct_move_r4: assert property (@(posedge clk) disable iff (!rstN)
    (gntVec != '0) |=> (gntVec == '0 || $stable(gntVec)));
  // R9: the master latched at revoke receives the grant
  p_latched_owner_r9: assert property (@(posedge clk) disable iff (!rstN)
    (gntVec == '0) |=> gntVec[$past(pendQ)]);
  // R3: with no requests the grant is parked
  p_parked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (gntVec != '0 && reqVec == '0) |=> $stable(gntVec));
endmodule

// File: rtl/parkArbiter.sv
module parkArbiter
  import parkArbPkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] busReq,
  input  logic                   frameN,
  input  logic                   irdyN,
  output logic [NUM_MASTERS-1:0] busGnt
);
  localparam int IdxW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

  arbStrobe_t      stb;
  logic [IdxW-1:0] ownerIdx, candIdx;
  logic            anyOther, started, ownerReq;

  assign ownerReq = busReq[ownerIdx];

  arbPicker #(.NUM_MASTERS(NUM_MASTERS)) uPick (
    .ownerIdx(ownerIdx), .reqVec(busReq), .candIdx(candIdx), .anyOther(anyOther));

  arbCtrl uCtrl (
    .clk(clk), .rstN(rstN), .anyOther(anyOther), .ownerReq(ownerReq),
    .started(started), .stb(stb));

  arbPath #(.NUM_MASTERS(NUM_MASTERS)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .candIdx(candIdx), .frameN(frameN),
    .irdyN(irdyN), .reqVec(busReq), .ownerIdx(ownerIdx), .started(started),
    .gntVec(busGnt));
endmodule

// File: tb/parkArbiter_test.sv
module parkArbiter_test;
  localparam int ClkPeriod = 10;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] busReq;
  logic       frameN, irdyN;
  logic [3:0] busGnt;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  parkArbiter #(.NUM_MASTERS(4)) uut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .frameN(frameN), .irdyN(irdyN),
    .busGnt(busGnt));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expectGnt(string tag, logic [3:0] exp);
    checks++;
    if (busGnt !== exp) begin
      fails++;
      $display("FAIL %s: grant %b, expected %b", tag, busGnt, exp);
    end
    checks++;
    if ($countones(busGnt) > 1) begin
      fails++;
      $display("FAIL R2: grant %b, expected at most one bit", busGnt);
    end
  endtask

  // R1: parked on master 0 under reset and just after
  task automatic tReset();
    rstN = 1'b0; busReq = '0; frameN = 1'b0; irdyN = 1'b0;
    step(); step();
    expectGnt("R1 in reset", 4'b0001);
    rstN = 1'b1;
    step();
    expectGnt("R1 after reset", 4'b0001);
  endtask

  // R6 then R7: owner not started keeps grant, start after idle lets go
  task automatic tKeepThenStart();
    busReq = 4'b0101;
    for (int i = 0; i < 3; i++) begin
      step();
      expectGnt("R6 busy since reset", 4'b0001);
    end
    frameN = 1'b1; irdyN = 1'b1;
    step();
    expectGnt("R6 idle cycle", 4'b0001);
    frameN = 1'b0;
    step();
    expectGnt("R7 revoke on start", 4'b0000);
    step();
    expectGnt("R4 new owner 2", 4'b0100);
    step();
    expectGnt("R6 new owner keeps", 4'b0100);
  endtask

  // R8 and R5: idle owner gives way; ascending order with wrap
  task automatic tRotate();
    busReq = 4'b1011;
    step();
    expectGnt("R8 owner 2 idle", 4'b0000);
    step();
    expectGnt("R5 next after 2 is 3", 4'b1000);
    busReq = 4'b0011;
    step();
    expectGnt("R8 owner 3 idle", 4'b0000);
    step();
    expectGnt("R5 wrap to 0", 4'b0001);
    busReq = 4'b0010;
    step();
    expectGnt("R4 gap", 4'b0000);
    step();
    expectGnt("R5 owner 1", 4'b0010);
  endtask

  // R9: latched next owner still granted after dropping its request
  task automatic tLatched();
    busReq = 4'b0100;
    step();
    expectGnt("R9 gap", 4'b0000);
    busReq = 4'b1000;
    step();
    expectGnt("R9 latched master 2", 4'b0100);
    step();
    expectGnt("R8 owner 2 gone", 4'b0000);
    step();
    expectGnt("R5 owner 3", 4'b1000);
  endtask

  // R3: parking on last owner with no requests or only own request
  task automatic tPark();
    busReq = '0; frameN = 1'b1; irdyN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      expectGnt("R3 parked on 3", 4'b1000);
    end
    busReq = 4'b1000; frameN = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      expectGnt("R3 only owner requests", 4'b1000);
    end
  endtask

  initial begin
    tReset();
    tKeepThenStart();
    tRotate();
    tLatched();
    tPark();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule